// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block collects eight interrupt request lines, ranks them by a fixed priority and raises a single interrupt output towards a processor. The processor programs it through a byte-wide register port that has two addresses: a command address and a data address. After reset the controller does nothing until software writes a start word to the command address and then the follow-up words to the data address. Those words set the vector base, the cascade arrangement and the end-of-interrupt style.

The processor answers the interrupt with a one-cycle acknowledge strobe. The controller then marks the winning input as in service and returns a vector byte, which is the programmed base plus the input number. A later command write ends service for one chosen input, unless automatic end-of-interrupt was selected. If the request vanished before the acknowledge, the controller still returns the vector of input 7, but it does not mark input 7 as in service. Software can therefore recognise the interrupt as spurious.

When the controller is a master, some inputs can be marked as carrying a downstream controller. An acknowledge that lands on such an input does not return a vector. Instead it publishes the input number on a cascade code output. When the controller is a slave, it holds an identity number and answers an acknowledge only when the cascade code presented to it matches that identity.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the mask reads back as 0xFF on the data address, the request and in-service registers are zero, and `int_out` stays low even with an unmasked request present, until an init sequence has completed.
- R2: A command write with bit 4 set starts initialization and clears the mask to 0x00 and the in-service register. The next data writes are taken as the base word, then the cascade word, then the mode word. The cascade word is skipped when bit 1 of the start word is 1, and the mode word is taken only when bit 0 of the start word is 1.
- R3: An acknowledge granted to input n returns `base + n` on `rdata`, with `vec_vld` high for one cycle, both in the cycle after the acknowledge.
- R4: Outside initialization, a data write loads the mask and a data read returns it unchanged. A masked input never raises `int_out`.
- R5: A command write of 0x0A makes later command reads return the request register. A command write of 0x0B makes them return the in-service register. The choice persists until it is rewritten, and after initialization the request register is selected.
- R6: Input 0 has the highest priority. `int_out` is high only when an unmasked pending request is of higher priority than every in-service bit.
- R7: A granted acknowledge sets the winner's in-service bit. It also clears the winner's request bit when that input is edge-triggered.
- R8: The command byte 0x60+n clears in-service bit n only. An acknowledge in the same cycle still takes effect.
- R9: With bit 1 of the mode word set (automatic end-of-interrupt), an acknowledge leaves the in-service register unchanged.
- R10: An acknowledge with no eligible request returns `base + 7` and leaves the in-service register unchanged.
- R11: `trig_lvl[n]`=1 makes request n follow the line level. `trig_lvl[n]`=0 latches a rising edge, and the latched request stays pending until it is acknowledged.
- R12: In master mode, an acknowledge won by an input whose bit is set in the cascade word sets its in-service bit. It then pulses `casc_vld` with `casc_id`=n and returns no vector.
- R13: In slave mode, bits 2:0 of the cascade word are the identity. An acknowledge with `casc_sel` different from the identity changes nothing and returns no vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; `rdata` is valid the next cycle |
| addr | input | 1 | 0 = command address, 1 = data address |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte or vector |
| irq | input | 8 | Interrupt request lines |
| trig_lvl | input | 8 | Per-input trigger select: 1 = level, 0 = edge |
| ack | input | 1 | Processor acknowledge strobe |
| vec_vld | output | 1 | `rdata` carries a vector this cycle |
| int_out | output | 1 | Interrupt request to the processor |
| slave_mode | input | 1 | 1 = slave, 0 = master |
| casc_sel | input | 3 | Cascade code presented to a slave |
| casc_vld | output | 1 | Master handed an acknowledge to a downstream controller |
| casc_id | output | 3 | Input number carrying that downstream controller |

## Verification
Two things can fall in the same clock edge: a specific end-of-interrupt for one in-service input, and an acknowledge that grants a different, higher-priority input. The bench first leaves input 4 in service. It then raises input 1 and drives the 0x64 command write together with the acknowledge in one cycle. It expects the vector for input 1 from the scoreboard and an in-service read of exactly 0x02, so the end-of-interrupt was not lost and the new bit was not dropped. A second overlap is the edge latch: a new rising edge meeting the acknowledge-driven clear. It is judged by request-register reads after pulses on edge inputs.

// File: rtl/ipc_pkg.sv
// Package: shared sizes, init sequencer states and priority helper for the
// interrupt controller. Assumes eight request inputs and byte-wide words.
package ipc_pkg;
    localparam int NIN = 8;
    localparam int IW  = $clog2(NIN);

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_BASE = 2'd1,
        SEQ_CASC = 2'd2,
        SEQ_MODE = 2'd3
    } seq_t;

    // Index of the lowest set bit (highest priority); zero when none set.
    function automatic logic [IW-1:0] low_index(input logic [NIN-1:0] v);
        logic [IW-1:0] r;
        r = '0;
        for (int i = NIN - 1; i >= 0; i--) begin
            if (v[i]) r = IW'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/ipc_regport.sv
// Register port and init sequencer. Decodes command and data writes, holds the
// mask, vector base, cascade word, end-of-interrupt style and read selection.
// Assumes a single write per cycle and synchronous active-low reset.
module ipc_regport
    import ipc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] imr,
    output logic [DW-1:0] base,
    output logic [DW-1:0] casc_word,
    output logic          aeoi,
    output logic          sel_isr,
    output logic          init_done,
    output logic          init_stb,
    output logic          eoi_stb,
    output logic [IW-1:0] eoi_idx
);
    seq_t seq;
    logic skip_casc;
    logic want_mode;

    logic cmd_wr, data_wr, is_start, is_rsel;
    assign cmd_wr   = wr_en && !addr;
    assign data_wr  = wr_en && addr;
    assign is_start = cmd_wr && wdata[4];
    assign is_rsel  = cmd_wr && !wdata[4] && wdata[3] && wdata[1];

    // Decode the one-shot strobes that the arbiter consumes.
    always_comb begin
        init_stb = is_start;
        eoi_stb  = cmd_wr && init_done && !wdata[4] && !wdata[3] && (wdata[7:5] == 3'b011);
        eoi_idx  = wdata[IW-1:0];
    end

    // Sequence the init words and hold the programmed state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq       <= SEQ_IDLE;
            imr       <= '1;
            base      <= '0;
            casc_word <= '0;
            aeoi      <= 1'b0;
            sel_isr   <= 1'b0;
            init_done <= 1'b0;
            skip_casc <= 1'b0;
            want_mode <= 1'b0;
        end else if (is_start) begin
            seq       <= SEQ_BASE;
            imr       <= '0;
            aeoi      <= 1'b0;
            sel_isr   <= 1'b0;
            init_done <= 1'b0;
            skip_casc <= wdata[1];
            want_mode <= wdata[0];
        end else if (is_rsel) begin
            sel_isr <= wdata[0];
        end else if (data_wr) begin
            unique case (seq)
                SEQ_BASE: begin
                    base <= wdata;
                    if (!skip_casc)     seq <= SEQ_CASC;
                    else if (want_mode) seq <= SEQ_MODE;
                    else begin
                        seq       <= SEQ_IDLE;
                        init_done <= 1'b1;
                    end
                end
                SEQ_CASC: begin
                    casc_word <= wdata;
                    if (want_mode) seq <= SEQ_MODE;
                    else begin
                        seq       <= SEQ_IDLE;
                        init_done <= 1'b1;
                    end
                end
                SEQ_MODE: begin
                    aeoi      <= wdata[1];
                    seq       <= SEQ_IDLE;
                    init_done <= 1'b1;
                end
                default: imr <= wdata;
            endcase
        end
    end

    assert_mask_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !is_start && seq == SEQ_IDLE) |=> (imr == $past(wdata)));

    assert_read_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
        is_rsel |=> (sel_isr == $past(wdata[0])));
endmodule

// File: rtl/ipc_reqcap.sv
// Request capture. Level inputs pass straight through; edge inputs latch a
// rising edge until the arbiter clears them on acknowledge or init restarts.
// Assumes the request lines are already synchronous to clk.
module ipc_reqcap
    import ipc_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NIN-1:0] irq,
    input  logic [NIN-1:0] trig_lvl,
    input  logic [NIN-1:0] clr_mask,
    input  logic           init_stb,
    output logic [NIN-1:0] irr
);
    logic [NIN-1:0] irq_q;
    logic [NIN-1:0] lat;

    // Track the previous line level and hold the latched edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '0;
            lat   <= '0;
        end else begin
            irq_q <= irq;
            if (init_stb) lat <= '0;
            else          lat <= ((lat & ~clr_mask) | (irq & ~irq_q)) & ~trig_lvl;
        end
    end

    // Per-input choice between live level and latched edge.
    generate
        for (genvar g = 0; g < NIN; g++) begin : g_sel
            assign irr[g] = trig_lvl[g] ? irq[g] : lat[g];
        end
    endgenerate

    assert_edge_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !init_stb |=> ((($past(lat) & ~$past(clr_mask) & ~$past(trig_lvl)) & ~lat) == '0));
endmodule

// File: rtl/ipc_arbiter.sv
// Priority resolution, in-service register, acknowledge handling, vector
// formation and cascade signalling. Input 0 is highest priority. Assumes at
// most one end-of-interrupt command per cycle.
module ipc_arbiter
    import ipc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NIN-1:0] irr,
    input  logic [NIN-1:0] imr,
    input  logic [NIN-1:0] trig_lvl,
    input  logic [DW-1:0]  base,
    input  logic [DW-1:0]  casc_word,
    input  logic           aeoi,
    input  logic           init_done,
    input  logic           init_stb,
    input  logic           eoi_stb,
    input  logic [IW-1:0]  eoi_idx,
    input  logic           ack,
    input  logic           slave_mode,
    input  logic [IW-1:0]  casc_sel,
    output logic [NIN-1:0] isr,
    output logic [NIN-1:0] edge_clr,
    output logic           int_out,
    output logic           give_vec,
    output logic [DW-1:0]  vec,
    output logic           casc_vld,
    output logic [IW-1:0]  casc_id
);
    logic [NIN-1:0] req, win_oh, eoi_oh;
    logic [IW-1:0]  req_idx, isr_idx;
    logic           eligible, respond, grant, to_casc;

    // Rank pending requests against the in-service level and form the grant.
    always_comb begin
        req      = irr & ~imr;
        req_idx  = low_index(req);
        isr_idx  = low_index(isr);
        eligible = (|req) && (!(|isr) || (req_idx < isr_idx));
        int_out  = init_done && eligible;
        respond  = ack && init_done && (!slave_mode || (casc_sel == casc_word[IW-1:0]));
        grant    = respond && eligible;
        win_oh   = grant ? (NIN'(1) << req_idx) : '0;
        to_casc  = grant && !slave_mode && casc_word[req_idx];
        edge_clr = win_oh & ~trig_lvl;
        eoi_oh   = eoi_stb ? (NIN'(1) << eoi_idx) : '0;
        give_vec = respond && !to_casc;
        vec      = base + DW'(grant ? req_idx : IW'(NIN - 1));
    end

    // Update in-service bits from grants and end-of-interrupt commands.
    always_ff @(posedge clk) begin
        if (!rst_n)        isr <= '0;
        else if (init_stb) isr <= '0;
        else               isr <= (isr & ~eoi_oh) | (aeoi ? '0 : win_oh);
    end

    // Register the cascade hand-off pulse and code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            casc_vld <= 1'b0;
            casc_id  <= '0;
        end else begin
            casc_vld <= to_casc;
            casc_id  <= req_idx;
        end
    end

    assert_uninit_isr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |=> (isr == '0));

    assert_spurious_isr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (respond && !eligible && !eoi_stb && !init_stb) |=> (isr == $past(isr)));

    assert_eoi_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_stb && !init_stb && !(grant && !aeoi && req_idx == eoi_idx))
        |=> !isr[$past(eoi_idx)]);

    assert_aeoi_no_growth_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (aeoi && !init_stb) |=> ($countones(isr) <= $countones($past(isr))));
endmodule

// File: rtl/irq_prio_ctrl.sv
// Top of the eight-input priority interrupt controller. Joins the register
// port, request capture and arbiter, and registers the read/vector byte.
// Assumes rd_en and ack are single-cycle strobes; ack wins the read byte.
module irq_prio_ctrl
    import ipc_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           rd_en,
    input  logic           addr,
    input  logic [7:0]     wdata,
    output logic [7:0]     rdata,
    input  logic [NIN-1:0] irq,
    input  logic [NIN-1:0] trig_lvl,
    input  logic           ack,
    output logic           vec_vld,
    output logic           int_out,
    input  logic           slave_mode,
    input  logic [IW-1:0]  casc_sel,
    output logic           casc_vld,
    output logic [IW-1:0]  casc_id
);
    localparam int DW = 8;

    logic [DW-1:0]  imr, base, casc_word, vec;
    logic [NIN-1:0] irr, isr, edge_clr;
    logic           aeoi, sel_isr, init_done, init_stb, eoi_stb, give_vec;
    logic [IW-1:0]  eoi_idx;

    ipc_regport #(.DW(DW)) u_regport (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .imr(imr), .base(base), .casc_word(casc_word), .aeoi(aeoi),
        .sel_isr(sel_isr), .init_done(init_done), .init_stb(init_stb),
        .eoi_stb(eoi_stb), .eoi_idx(eoi_idx)
    );

    ipc_reqcap u_reqcap (
        .clk(clk), .rst_n(rst_n), .irq(irq), .trig_lvl(trig_lvl),
        .clr_mask(edge_clr), .init_stb(init_stb), .irr(irr)
    );

    ipc_arbiter #(.DW(DW)) u_arbiter (
        .clk(clk), .rst_n(rst_n), .irr(irr), .imr(imr), .trig_lvl(trig_lvl),
        .base(base), .casc_word(casc_word), .aeoi(aeoi), .init_done(init_done),
        .init_stb(init_stb), .eoi_stb(eoi_stb), .eoi_idx(eoi_idx), .ack(ack),
        .slave_mode(slave_mode), .casc_sel(casc_sel), .isr(isr),
        .edge_clr(edge_clr), .int_out(int_out), .give_vec(give_vec), .vec(vec),
        .casc_vld(casc_vld), .casc_id(casc_id)
    );

    // Register the outgoing byte: vector on acknowledge, else the selected register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata   <= '0;
            vec_vld <= 1'b0;
        end else begin
            vec_vld <= give_vec;
            if (give_vec)   rdata <= vec;
            else if (rd_en) rdata <= addr ? imr : (sel_isr ? isr : irr);
        end
    end

    assert_vector_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
        give_vec |=> (vec_vld && rdata[7:3] == $past(base[7:3])));
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, ack = 1'b0;
    logic [7:0] wdata = '0, irq = '0, trig_lvl = 8'h88;
    logic       slave_mode = 1'b0;
    logic [2:0] casc_sel = '0;
    logic [7:0] rdata;
    logic       vec_vld, int_out, casc_vld;
    logic [2:0] casc_id;

    int checks = 0, failures = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;

    irq_prio_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .trig_lvl(trig_lvl), .ack(ack),
        .vec_vld(vec_vld), .int_out(int_out), .slave_mode(slave_mode),
        .casc_sel(casc_sel), .casc_vld(casc_vld), .casc_id(casc_id)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Scoreboard monitor: every vector must match the oldest expected one.
    always @(negedge clk) begin
        if (rst_n && vec_vld) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R3 actual=%h expected=none", rdata);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (rdata !== e) begin
                    failures++;
                    $display("FAIL R3 actual=%h expected=%h", rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(posedge clk); @(negedge clk); rd_en = 1'b0; v = rdata;
    endtask

    task automatic do_ack(input bit want_vec, input logic [7:0] v);
        if (want_vec) exp_q.push_back(v);
        @(negedge clk); ack = 1'b1;
        @(posedge clk); @(negedge clk); ack = 1'b0;
    endtask

    task automatic pulse(input int n);
        @(negedge clk); irq[n] = 1'b1;
        @(negedge clk); irq[n] = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state, no output before init even with a level request.
        rd(1'b1, v); check("R1 mask", v, 8'hFF);
        rd(1'b0, v); check("R1 irr", v, 8'h00);
        @(negedge clk); irq[3] = 1'b1;
        @(negedge clk); check("R1 int_out", {7'd0, int_out}, 8'h00);
        irq[3] = 1'b0;

        // R2: master init: base 0x20, slave on input 2, normal EOI.
        wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h00);
        rd(1'b1, v); check("R2 mask cleared", v, 8'h00);

        // R4/R5: masked edge request is pending but silent.
        wr(1'b1, 8'hFF);
        pulse(1);
        @(negedge clk); check("R4 masked", {7'd0, int_out}, 8'h00);
        wr(1'b0, 8'h0A); rd(1'b0, v); check("R5 irr read", v, 8'h02);
        rd(1'b1, v); check("R4 mask read", v, 8'hFF);
        wr(1'b1, 8'h00);
        check("R4 unmasked", {7'd0, int_out}, 8'h01);

        // R3/R7: acknowledge input 1.
        do_ack(1'b1, 8'h21);
        wr(1'b0, 8'h0B); rd(1'b0, v); check("R7 isr set", v, 8'h02);
        rd(1'b0, v); check("R5 select persists", v, 8'h02);
        wr(1'b0, 8'h0A); rd(1'b0, v); check("R7 edge cleared", v, 8'h00);

        // R6/R8: priority against in-service levels.
        @(negedge clk); irq[0] = 1'b1; irq[5] = 1'b1;
        @(negedge clk); irq[0] = 1'b0; irq[5] = 1'b0;
        check("R6 higher than isr", {7'd0, int_out}, 8'h01);
        do_ack(1'b1, 8'h20);
        check("R6 lower than isr", {7'd0, int_out}, 8'h00);
        wr(1'b0, 8'h60);
        wr(1'b0, 8'h0B); rd(1'b0, v); check("R8 only bit0", v, 8'h02);
        check("R6 still blocked", {7'd0, int_out}, 8'h00);
        wr(1'b0, 8'h61);
        check("R6 released", {7'd0, int_out}, 8'h01);
        do_ack(1'b1, 8'h25);
        wr(1'b0, 8'h65);

        // R10/R11: level request withdrawn before acknowledge.
        wr(1'b0, 8'h0A);
        @(negedge clk); irq[3] = 1'b1;
        rd(1'b0, v); check("R11 level follows", v, 8'h08);
        @(negedge clk); irq[3] = 1'b0;
        @(negedge clk); check("R11 level gone", {7'd0, int_out}, 8'h00);
        do_ack(1'b1, 8'h27);
        wr(1'b0, 8'h0B); rd(1'b0, v); check("R10 isr untouched", v, 8'h00);

        // R11: edge pulse stays latched.
        wr(1'b0, 8'h0A);
        pulse(6);
        rd(1'b0, v); check("R11 edge held", v, 8'h40);
        do_ack(1'b1, 8'h26);
        wr(1'b0, 8'h66);

        // R12: acknowledge on cascaded input 2.
        pulse(2);
        do_ack(1'b0, 8'h00);
        check("R12 casc_vld", {7'd0, casc_vld}, 8'h01);
        check("R12 casc_id", {5'd0, casc_id}, 8'h02);
        wr(1'b0, 8'h0B); rd(1'b0, v); check("R12 isr", v, 8'h04);
        wr(1'b0, 8'h62);

        // R8: end-of-interrupt and acknowledge in one cycle.
        pulse(4);
        do_ack(1'b1, 8'h24);
        pulse(1);
        check("R6 preempt", {7'd0, int_out}, 8'h01);
        exp_q.push_back(8'h21);
        @(negedge clk); addr = 1'b0; wdata = 8'h64; wr_en = 1'b1; ack = 1'b1;
        @(posedge clk); @(negedge clk); wr_en = 1'b0; ack = 1'b0;
        rd(1'b0, v); check("R8 eoi with ack", v, 8'h02);
        wr(1'b0, 8'h61);

        // R2/R9: single mode skips the cascade word; automatic EOI.
        wr(1'b0, 8'h13); wr(1'b1, 8'h40); wr(1'b1, 8'h02);
        rd(1'b1, v); check("R2 third word is mode", v, 8'h00);
        pulse(0);
        do_ack(1'b1, 8'h40);
        wr(1'b0, 8'h0B); rd(1'b0, v); check("R9 aeoi isr", v, 8'h00);

        // R13: slave with identity 5.
        slave_mode = 1'b1;
        wr(1'b0, 8'h11); wr(1'b1, 8'h50); wr(1'b1, 8'h05); wr(1'b1, 8'h00);
        pulse(2);
        casc_sel = 3'd3;
        do_ack(1'b0, 8'h00);
        wr(1'b0, 8'h0B); rd(1'b0, v); check("R13 wrong id isr", v, 8'h00);
        check("R13 still pending", {7'd0, int_out}, 8'h01);
        casc_sel = 3'd5;
        do_ack(1'b1, 8'h52);
        rd(1'b0, v); check("R13 match isr", v, 8'h04);

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R3 actual=%0d expected=0 vectors outstanding", exp_q.size());
        end
        summary();
    end
endmodule